// File: doc/BRIEF.md
# Processor Control Register File

This block keeps the machine-wide control state of a 32-bit protected-mode processor in three architectural registers: a control word carrying the mode and coprocessor flags, a register that captures the linear address of the most recent page fault, and the base address of the page directory. Instruction decode, the paging unit and exception dispatch live elsewhere. They reach this block through simple one-cycle strobes that carry an index and data.

Software can move a whole 32-bit value into or out of any register by index. It can also load or store only the low 16 bits of the control word, the status word. Hardware events change the state directly. A task switch marks the control word as task-switched and flushes the translation cache. A page fault records its address. The block decides whether a coprocessor or WAIT instruction must raise exception 7, and it drives the protection-enable and paging-enable levels to the rest of the core.

Top module: `sys_ctl_regs`

## Requirements
- R1: After reset every register reads zero, `prot_en`, `page_en`, `flush_xlat` and `xcpt7_req` are low, and the core starts in real mode with paging off.
- R2: A full write (`mov_wr`) to index 0 stores only the defined control-word bits: 31 (paging), 3 (task switched), 2 (emulate coprocessor), 1 (monitor coprocessor) and 0 (protection). All other bits read back as zero, and a read at index 0 returns the whole 32-bit word.
- R3: A status-word load (`sw_wr`) changes only bits 15:0 of the control word, and `sw_out` always shows bits 15:0. When a full write to index 0 arrives in the same cycle, the full write wins.
- R4: A task-switch strobe sets bit 3 of the control word on the next edge. This holds even when a full write that clears bit 3 arrives in the same cycle.
- R5: A coprocessor-op strobe raises `xcpt7_req` for one cycle, on the edge after the strobe, exactly when bit 2 is 1.
- R6: A WAIT strobe raises `xcpt7_req` for one cycle, on the edge after the strobe, only when bits 1 and 3 are both 1.
- R7: A page-fault strobe latches `pf_addr` into index 2. When a full write to index 2 arrives in the same cycle, the captured fault address wins.
- R8: Index 3 holds a 4 KB-aligned base address: written bits 11:0 are dropped and read back as zero.
- R9: `flush_xlat` pulses high for exactly one cycle after a task-switch strobe or a full write to index 3.
- R10: Index 1 is reserved: it reads as zero, and a write to it changes no register.
- R11: `prot_en` follows control-word bit 0 and `page_en` follows bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 2 | Register index for full moves (0 control, 1 reserved, 2 fault address, 3 directory base) |
| mov_wr | input | 1 | Full 32-bit write strobe |
| mov_wdata | input | 32 | Full write data |
| mov_rdata | output | 32 | Full read data for `reg_idx` |
| sw_wr | input | 1 | Status-word load strobe |
| sw_wdata | input | 16 | Status-word load data |
| sw_out | output | 16 | Status-word store value (control bits 15:0) |
| task_sw | input | 1 | Task-switch event strobe |
| pf_evt | input | 1 | Page-fault event strobe |
| pf_addr | input | 32 | Faulting linear address |
| copro_op | input | 1 | Coprocessor instruction strobe |
| wait_op | input | 1 | WAIT instruction strobe |
| prot_en | output | 1 | Protected mode enabled |
| page_en | output | 1 | Paging enabled |
| flush_xlat | output | 1 | One-cycle translation-cache invalidate |
| xcpt7_req | output | 1 | One-cycle coprocessor-not-available request |

## Verification
The bench drives the collisions in which a wrong priority would go unnoticed. In one, a task switch arrives alongside a write that clears the task-switched flag: a design that lets software win leaves TS at 0. In another, a page fault coincides with a software write to the fault register, and a reversed priority would lose the faulting address. A full write is also issued together with a status-word load, so that a merge of the two shows up as corrupted low bits.

The WAIT decision is tested with only MP set and with only TS set. A design that used OR instead of AND would fault in both cases. Further stimulus writes all ones, which exposes reserved bits that fail to read zero. It also writes a directory base whose offset bits are nonzero, and writes to index 1, which would show a leak into a neighbouring register.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned PG_SHIFT = 12;
  localparam int unsigned IDX_W    = 2;

  localparam int unsigned BIT_PE = 0;
  localparam int unsigned BIT_MP = 1;
  localparam int unsigned BIT_EM = 2;
  localparam int unsigned BIT_TS = 3;
  localparam int unsigned BIT_PG = WORD_W - 1;

  localparam logic [WORD_W-1:0] CW_DEFINED =
    (WORD_W'(1) << BIT_PG) | (WORD_W'(1) << BIT_TS) |
    (WORD_W'(1) << BIT_EM) | (WORD_W'(1) << BIT_MP) |
    (WORD_W'(1) << BIT_PE);

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 2'd0,
    IDX_RSVD  = 2'd1,
    IDX_FADDR = 2'd2,
    IDX_DBASE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic pg;
    logic ts;
    logic em;
    logic mp;
    logic pe;
  } cw_flags_t;
endpackage

// File: rtl/ctl_word.sv
module ctl_word
  import ctlreg_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_wr,
  input  logic [W-1:0]  full_data,
  input  logic          stat_wr,
  input  logic [SW-1:0] stat_data,
  input  logic          ts_set,
  output logic [W-1:0]  cw,
  output cw_flags_t     flags
);
  localparam logic [W-1:0] MASK = W'(CW_DEFINED);

  logic [W-1:0] cw_q, cw_d;
  logic         cw_en;

  always_comb begin
    cw_d = cw_q;
    if (full_wr) begin
      cw_d = full_data & MASK;
    end else if (stat_wr) begin
      cw_d = {cw_q[W-1:SW], stat_data} & MASK;
    end
    if (ts_set) begin
      cw_d[BIT_TS] = 1'b1;
    end
  end

  assign cw_en = full_wr | stat_wr | ts_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q <= '0;
    end else if (cw_en) begin
      cw_q <= cw_d;
    end
  end

  assign cw       = cw_q;
  assign flags.pg = cw_q[W-1];
  assign flags.ts = cw_q[BIT_TS];
  assign flags.em = cw_q[BIT_EM];
  assign flags.mp = cw_q[BIT_MP];
  assign flags.pe = cw_q[BIT_PE];

  assert_ts_hw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ts_set |=> cw_q[BIT_TS]);

  assert_stat_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !full_wr) |=> cw_q[W-1:SW] == $past(cw_q[W-1:SW]));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_wr && !stat_wr && !ts_set) |=> $stable(cw_q));
endmodule

// File: rtl/addr_regs.sv
module addr_regs
  import ctlreg_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned PS = PG_SHIFT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fa_wr,
  input  logic         db_wr,
  input  logic [W-1:0] wdata,
  input  logic         pf_evt,
  input  logic [W-1:0] pf_addr,
  output logic [W-1:0] fault_addr,
  output logic [W-1:0] dir_base
);
  logic [W-1:0]    fa_q, fa_d;
  logic            fa_en;
  logic [W-PS-1:0] db_q, db_d;
  logic            db_en;

  always_comb begin
    fa_en = pf_evt | fa_wr;
    fa_d  = pf_evt ? pf_addr : wdata;
    db_en = db_wr;
    db_d  = wdata[W-1:PS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= '0;
    end else if (fa_en) begin
      fa_q <= fa_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q <= '0;
    end else if (db_en) begin
      db_q <= db_d;
    end
  end

  assign fault_addr = fa_q;
  assign dir_base   = {db_q, {PS{1'b0}}};

  assert_pf_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_evt |=> fa_q == $past(pf_addr));

  assert_base_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    db_wr |=> dir_base[W-1:PS] == $past(wdata[W-1:PS]));
endmodule

// File: rtl/event_logic.sv
module event_logic
  import ctlreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cw_flags_t flags,
  input  logic      copro_op,
  input  logic      wait_op,
  input  logic      task_sw,
  input  logic      base_wr,
  output logic      xcpt7,
  output logic      flush
);
  logic x7_q, x7_d;
  logic fl_q, fl_d;
  logic ev_en;

  always_comb begin
    x7_d  = (copro_op & flags.em) | (wait_op & flags.mp & flags.ts);
    fl_d  = task_sw | base_wr;
    ev_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x7_q <= 1'b0;
      fl_q <= 1'b0;
    end else if (ev_en) begin
      x7_q <= x7_d;
      fl_q <= fl_d;
    end
  end

  assign xcpt7 = x7_q;
  assign flush = fl_q;

  assert_em_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (copro_op && flags.em) |=> xcpt7);

  assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_op && !copro_op && !(flags.mp && flags.ts)) |=> !xcpt7);

  assert_flush_ts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> flush);

  assert_no_spurious_x7_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!copro_op && !wait_op) |=> !xcpt7);
endmodule

// File: rtl/sys_ctl_regs.sv
module sys_ctl_regs
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              mov_wr,
  input  logic [WORD_W-1:0] mov_wdata,
  output logic [WORD_W-1:0] mov_rdata,
  input  logic              sw_wr,
  input  logic [STAT_W-1:0] sw_wdata,
  output logic [STAT_W-1:0] sw_out,
  input  logic              task_sw,
  input  logic              pf_evt,
  input  logic [WORD_W-1:0] pf_addr,
  input  logic              copro_op,
  input  logic              wait_op,
  output logic              prot_en,
  output logic              page_en,
  output logic              flush_xlat,
  output logic              xcpt7_req
);
  reg_sel_e          sel;
  logic              wr_ctrl, wr_fa, wr_db;
  logic [WORD_W-1:0] cw, fa, db;
  cw_flags_t         flags;

  always_comb begin
    sel     = reg_sel_e'(reg_idx);
    wr_ctrl = mov_wr && (sel == IDX_CTRL);
    wr_fa   = mov_wr && (sel == IDX_FADDR);
    wr_db   = mov_wr && (sel == IDX_DBASE);
  end

  ctl_word #(.W(WORD_W), .SW(STAT_W)) u_cw (
    .clk       (clk),
    .rst_n     (rst_n),
    .full_wr   (wr_ctrl),
    .full_data (mov_wdata),
    .stat_wr   (sw_wr),
    .stat_data (sw_wdata),
    .ts_set    (task_sw),
    .cw        (cw),
    .flags     (flags)
  );

  addr_regs #(.W(WORD_W), .PS(PG_SHIFT)) u_ar (
    .clk        (clk),
    .rst_n      (rst_n),
    .fa_wr      (wr_fa),
    .db_wr      (wr_db),
    .wdata      (mov_wdata),
    .pf_evt     (pf_evt),
    .pf_addr    (pf_addr),
    .fault_addr (fa),
    .dir_base   (db)
  );

  event_logic u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (flags),
    .copro_op (copro_op),
    .wait_op  (wait_op),
    .task_sw  (task_sw),
    .base_wr  (wr_db),
    .xcpt7    (xcpt7_req),
    .flush    (flush_xlat)
  );

  always_comb begin
    unique case (sel)
      IDX_CTRL:  mov_rdata = cw;
      IDX_FADDR: mov_rdata = fa;
      IDX_DBASE: mov_rdata = db;
      default:   mov_rdata = '0;
    endcase
  end

  assign sw_out  = cw[STAT_W-1:0];
  assign prot_en = flags.pe;
  assign page_en = flags.pg;

  assert_rsvd_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == IDX_RSVD) |-> mov_rdata == '0);

  assert_flush_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_db |=> flush_xlat);

  assert_rsvd_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mov_wr && sel == IDX_RSVD && !sw_wr && !task_sw && !pf_evt) |=>
      ($stable(cw) && $stable(fa) && $stable(db)));
endmodule

// File: tb/sim_sys_ctl_regs.sv
module sim_sys_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic        mov_wr = 1'b0;
  logic [31:0] mov_wdata = '0;
  logic [31:0] mov_rdata;
  logic        sw_wr = 1'b0;
  logic [15:0] sw_wdata = '0;
  logic [15:0] sw_out;
  logic        task_sw = 1'b0;
  logic        pf_evt = 1'b0;
  logic [31:0] pf_addr = '0;
  logic        copro_op = 1'b0;
  logic        wait_op = 1'b0;
  logic        prot_en, page_en, flush_xlat, xcpt7_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sys_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .mov_wr(mov_wr),
    .mov_wdata(mov_wdata), .mov_rdata(mov_rdata), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .sw_out(sw_out), .task_sw(task_sw),
    .pf_evt(pf_evt), .pf_addr(pf_addr), .copro_op(copro_op),
    .wait_op(wait_op), .prot_en(prot_en), .page_en(page_en),
    .flush_xlat(flush_xlat), .xcpt7_req(xcpt7_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] v);
    reg_idx = idx;
    #1;
    v = mov_rdata;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; mov_wdata = d; mov_wr = 1'b1;
    @(negedge clk);
    mov_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], v);
      chk("R1 reg zero", v, 0);
    end
    chk("R1 prot_en", {31'b0, prot_en}, 0);
    chk("R1 page_en", {31'b0, page_en}, 0);
    chk("R1 flush", {31'b0, flush_xlat}, 0);
    chk("R1 xcpt7", {31'b0, xcpt7_req}, 0);
  endtask

  task automatic t_full_write;
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v);
    chk("R2 defined bits only", v, 32'h8000_000F);
    chk("R11 prot_en", {31'b0, prot_en}, 1);
    chk("R11 page_en", {31'b0, page_en}, 1);
    wr(2'd0, 32'h0000_0001);
    chk("R11 page_en off", {31'b0, page_en}, 0);
    chk("R11 prot_en on", {31'b0, prot_en}, 1);
  endtask

  task automatic t_status_word;
    logic [31:0] v;
    wr(2'd0, 32'h8000_0000);
    @(negedge clk);
    sw_wdata = 16'hFFFF; sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
    rd(2'd0, v);
    chk("R3 load keeps upper", v, 32'h8000_000F);
    chk("R3 store low half", {16'b0, sw_out}, 32'h0000_000F);
    @(negedge clk);
    reg_idx = 2'd0; mov_wdata = 32'h8000_0001; mov_wr = 1'b1;
    sw_wdata = 16'h0006; sw_wr = 1'b1;
    @(negedge clk);
    mov_wr = 1'b0; sw_wr = 1'b0;
    rd(2'd0, v);
    chk("R3 full write wins", v, 32'h8000_0001);
  endtask

  task automatic t_task_switch;
    logic [31:0] v;
    wr(2'd0, 32'h0);
    @(negedge clk);
    reg_idx = 2'd0; mov_wdata = 32'h0000_0002; mov_wr = 1'b1; task_sw = 1'b1;
    @(negedge clk);
    mov_wr = 1'b0; task_sw = 1'b0;
    rd(2'd0, v);
    chk("R4 TS beats write", v, 32'h0000_000A);
    chk("R9 flush after task switch", {31'b0, flush_xlat}, 1);
    @(negedge clk);
    chk("R9 flush one cycle", {31'b0, flush_xlat}, 0);
  endtask

  task automatic strobe(input bit is_wait, input logic [31:0] cwv, input bit exp, input string tag);
    wr(2'd0, cwv);
    @(negedge clk);
    if (is_wait) wait_op = 1'b1; else copro_op = 1'b1;
    @(negedge clk);
    wait_op = 1'b0; copro_op = 1'b0;
    chk(tag, {31'b0, xcpt7_req}, {31'b0, exp});
    @(negedge clk);
    chk({tag, " drop"}, {31'b0, xcpt7_req}, 0);
  endtask

  task automatic t_exceptions;
    strobe(1'b0, 32'h4, 1'b1, "R5 copro EM=1");
    strobe(1'b0, 32'h0, 1'b0, "R5 copro EM=0");
    strobe(1'b0, 32'hA, 1'b0, "R5 copro MP TS no EM");
    strobe(1'b1, 32'hA, 1'b1, "R6 wait MP=1 TS=1");
    strobe(1'b1, 32'h2, 1'b0, "R6 wait MP only");
    strobe(1'b1, 32'h8, 1'b0, "R6 wait TS only");
  endtask

  task automatic t_fault_addr;
    logic [31:0] v;
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, v);
    chk("R7 software write", v, 32'h1234_5678);
    @(negedge clk);
    pf_addr = 32'hDEAD_BEEF; pf_evt = 1'b1;
    reg_idx = 2'd2; mov_wdata = 32'h0BAD_F00D; mov_wr = 1'b1;
    @(negedge clk);
    pf_evt = 1'b0; mov_wr = 1'b0;
    rd(2'd2, v);
    chk("R7 fault wins", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_dir_base;
    logic [31:0] v;
    @(negedge clk);
    reg_idx = 2'd3; mov_wdata = 32'hABCD_EFFF; mov_wr = 1'b1;
    @(negedge clk);
    mov_wr = 1'b0;
    chk("R9 flush after base write", {31'b0, flush_xlat}, 1);
    rd(2'd3, v);
    chk("R8 offset dropped", v, 32'hABCD_E000);
    @(negedge clk);
    chk("R9 base flush one cycle", {31'b0, flush_xlat}, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    wr(2'd0, 32'h8000_0003);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v);
    chk("R10 reserved reads zero", v, 0);
    rd(2'd0, v);
    chk("R10 ctrl untouched", v, 32'h8000_0003);
    rd(2'd2, v);
    chk("R10 fault untouched", v, 32'hDEAD_BEEF);
    rd(2'd3, v);
    chk("R10 base untouched", v, 32'hABCD_E000);
    chk("R10 no flush", {31'b0, flush_xlat}, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_status_word();
    t_task_switch();
    t_exceptions();
    t_fault_addr();
    t_dir_base();
    t_reserved();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule